// File: doc/BRIEF.md
# Low-Power Hold Sequencer

This block puts a small controller core into a low-power hold state and brings it back out. A command write from the core side asks for hold and picks how hold will end: either while a wake line is at a high level, or on a rising edge of that line. During hold the block turns off the oscillator enable, keeps the core frozen and holds the timing-generator counter in clear. Memory, registers and the program counter are not part of this block. The block only drives the enable, freeze and clear signals, and the state elsewhere keeps its contents because of them.

The wake line the block uses is the external hold pin ANDed with an output-port latch bit, so software must set that latch before the pin has any effect. The effective line passes through a short synchronizer. A status bit reports its level so that software can poll it before asking for hold. When hold is released, the oscillator runs again and a counter on the free-running clock measures a fixed warm-up interval of 2^WARM_BITS cycles (2^14 by default). After that interval the core is unfrozen and a one-cycle restart pulse is issued. If a level-mode hold is asked for while the wake line is already high, the block skips hold and goes straight into warm-up.

Top module: `hold_top`

## Requirements
- R1: After a synchronous active-low reset the core is running: oscEn=1, cpuFreeze=0, tgClear=0, cpuRun=0.
- R2: statusHold equals holdPin AND portLatch, delayed by SYNC_STAGES clock cycles (default 2).
- R3: A write of code 4'b1101 (level mode) while statusHold is 0 enters hold from the next cycle on: oscEn=0, cpuFreeze=1, tgClear=1.
- R4: A level-mode hold ends in the cycle after statusHold is seen high, and warm-up follows.
- R5: A write of code 4'b1101 while statusHold is 1 skips hold: oscEn stays 1, tgClear stays 0, and warm-up starts at once.
- R6: A write of code 4'b1010 (edge mode) enters hold whatever the wake level is.
- R7: An edge-mode hold ends only on a 0-to-1 change of statusHold after entry. A level that stays high and a falling level leave hold unchanged.
- R8: Warm-up lasts exactly 2^WARM_BITS cycles, with oscEn=1, cpuFreeze=1 and tgClear=0 throughout.
- R9: cpuRun is high for exactly one cycle, the first cycle in which cpuFreeze is low again after warm-up.
- R10: Writes of any other code are ignored, and so is every write made during hold or warm-up. The outputs stay as they were.
- R11: With portLatch at 0 the pin cannot release a level-mode hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdData | input | 4 | Command code |
| holdPin | input | 1 | External hold/wake pin |
| portLatch | input | 1 | Port output latch bit that gates the pin |
| oscEn | output | 1 | Oscillator enable |
| cpuFreeze | output | 1 | Freezes core advance |
| tgClear | output | 1 | Holds timing generator at zero |
| cpuRun | output | 1 | One-cycle restart pulse after warm-up |
| statusHold | output | 1 | Status bit 0: synchronized wake level |

## Verification
A wrong internal state shows up at the ports within one cycle. A stuck or wrong sequencer state gives a mix of oscEn, cpuFreeze and tgClear that does not fit the last command and wake stimulus, and the bench samples these outputs in every cycle after each write. A wrong count in the warm-up counter changes how many frozen cycles with the oscillator on come before cpuRun, and the bench checks that number exactly. An edge detector that is armed wrongly makes an edge-mode hold end during a steady high level, and that shows at tgClear in the next cycle.

// File: rtl/hold_pkg.sv
package hold_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_WARM = 2'd2
  } holdState_t;

  localparam logic [3:0] CMD_HOLD_LEVEL = 4'b1101;
  localparam logic [3:0] CMD_HOLD_EDGE  = 4'b1010;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic runPulse;
  } dpStrobe_t;

endpackage

// File: rtl/hold_datapath.sv
module hold_datapath
  import hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WARM_BITS   = 14
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      holdPin,
  input  logic      portLatch,
  input  dpStrobe_t strobe,
  output logic      holdLvl,
  output logic      holdRise,
  output logic      warmDone,
  output logic      cpuRun
);

  localparam logic [WARM_BITS-1:0] CNT_LAST = {WARM_BITS{1'b1}};

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLvl;
  logic [WARM_BITS-1:0]   warmCnt;
  logic                   runQ;

  // wake synchronizer: first stage takes the gated pin
  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= holdPin & portLatch;
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  endgenerate

  assign holdLvl = syncQ[SYNC_STAGES-1];

  // level history for rising-edge detection
  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= holdLvl;
  end

  assign holdRise = holdLvl & ~prevLvl;

  // warm-up counter on the free-running clock
  always_ff @(posedge clk) begin
    if (!rstN)                warmCnt <= '0;
    else if (strobe.cntClear) warmCnt <= '0;
    else if (strobe.cntStep)  warmCnt <= warmCnt + 1'b1;
  end

  assign warmDone = (warmCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) runQ <= 1'b0;
    else       runQ <= strobe.runPulse;
  end

  assign cpuRun = runQ;

endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
  import hold_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrEn,
  input  logic [3:0] cmdData,
  input  logic       holdLvl,
  input  logic       holdRise,
  input  logic       warmDone,
  output dpStrobe_t  strobe,
  output logic       edgeMode,
  output logic       oscEn,
  output logic       cpuFreeze,
  output logic       tgClear
);

  holdState_t state, stateNext;
  logic       modeQ, modeNext;
  logic       release_;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
      modeQ <= 1'b0;
    end else begin
      state <= stateNext;
      modeQ <= modeNext;
    end
  end

  assign release_ = modeQ ? holdRise : holdLvl;

  always_comb begin
    stateNext = state;
    modeNext  = modeQ;
    strobe    = '0;
    unique case (state)
      ST_RUN: begin
        if (cmdWrEn && cmdData == CMD_HOLD_LEVEL) begin
          modeNext = 1'b0;
          if (holdLvl) begin
            stateNext       = ST_WARM;
            strobe.cntClear = 1'b1;
          end else begin
            stateNext = ST_HOLD;
          end
        end else if (cmdWrEn && cmdData == CMD_HOLD_EDGE) begin
          modeNext  = 1'b1;
          stateNext = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (release_) begin
          stateNext       = ST_WARM;
          strobe.cntClear = 1'b1;
        end
      end
      ST_WARM: begin
        strobe.cntStep = 1'b1;
        if (warmDone) begin
          stateNext       = ST_RUN;
          strobe.runPulse = 1'b1;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  assign edgeMode  = modeQ;
  assign oscEn     = (state != ST_HOLD);
  assign cpuFreeze = (state != ST_RUN);
  assign tgClear   = (state == ST_HOLD);

endmodule

// File: rtl/hold_top.sv
module hold_top
  import hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WARM_BITS   = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrEn,
  input  logic [3:0] cmdData,
  input  logic       holdPin,
  input  logic       portLatch,
  output logic       oscEn,
  output logic       cpuFreeze,
  output logic       tgClear,
  output logic       cpuRun,
  output logic       statusHold
);

  dpStrobe_t strobe;
  logic      holdLvl;
  logic      holdRise;
  logic      warmDone;
  logic      edgeMode;

  hold_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrEn  (cmdWrEn),
    .cmdData  (cmdData),
    .holdLvl  (holdLvl),
    .holdRise (holdRise),
    .warmDone (warmDone),
    .strobe   (strobe),
    .edgeMode (edgeMode),
    .oscEn    (oscEn),
    .cpuFreeze(cpuFreeze),
    .tgClear  (tgClear)
  );

  hold_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .WARM_BITS  (WARM_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .holdPin  (holdPin),
    .portLatch(portLatch),
    .strobe   (strobe),
    .holdLvl  (holdLvl),
    .holdRise (holdRise),
    .warmDone (warmDone),
    .cpuRun   (cpuRun)
  );

  assign statusHold = holdLvl;

endmodule

// File: rtl/hold_chk.sv
module hold_chk #(
  parameter int WARM_BITS = 14
) (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWrEn,
  input logic [3:0] cmdData,
  input logic       oscEn,
  input logic       cpuFreeze,
  input logic       tgClear,
  input logic       cpuRun,
  input logic       statusHold,
  input logic       edgeMode
);

  localparam int WARM_LEN = 1 << WARM_BITS;

  logic [WARM_BITS+1:0] warmSeen;

  always_ff @(posedge clk) begin
    if (!rstN)                  warmSeen <= '0;
    else if (cpuFreeze && oscEn) warmSeen <= warmSeen + 1'b1;
    else                        warmSeen <= '0;
  end

  AST_HOLD_GATES: assert property (@(posedge clk) disable iff (!rstN)
    tgClear |-> (!oscEn && cpuFreeze)); // R3

  AST_HOLD_FROM_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oscEn) |-> $past(!cpuFreeze)); // R3

  AST_WARM_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscEn) |-> (cpuFreeze && !tgClear)); // R8

  AST_WARM_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    cpuRun |-> (warmSeen == WARM_LEN)); // R8

  AST_RUN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuRun |-> (!cpuFreeze && $past(cpuFreeze))); // R9

  AST_RUN_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cpuRun |=> !cpuRun); // R9

  AST_IGNORE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && !cpuFreeze && cmdData != 4'b1101 && cmdData != 4'b1010)
      |=> (!cpuFreeze && oscEn)); // R10

  AST_EDGE_NO_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (tgClear && edgeMode && statusHold && $past(statusHold)) |=> tgClear); // R7

endmodule

bind hold_top hold_chk #(.WARM_BITS(WARM_BITS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdWrEn   (cmdWrEn),
  .cmdData   (cmdData),
  .oscEn     (oscEn),
  .cpuFreeze (cpuFreeze),
  .tgClear   (tgClear),
  .cpuRun    (cpuRun),
  .statusHold(statusHold),
  .edgeMode  (edgeMode)
);

// File: tb/tb_hold_top.sv
module tb_hold_top;

  localparam int WB = 6;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cmdWrEn;
  logic [3:0] cmdData;
  logic       holdPin;
  logic       portLatch;
  logic       oscEn, cpuFreeze, tgClear, cpuRun, statusHold;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hold_top #(.SYNC_STAGES(2), .WARM_BITS(WB)) dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdData(cmdData),
    .holdPin(holdPin), .portLatch(portLatch), .oscEn(oscEn),
    .cpuFreeze(cpuFreeze), .tgClear(tgClear), .cpuRun(cpuRun),
    .statusHold(statusHold)
  );

  function automatic int expStatus(logic p, logic l);
    return int'(p & l);
  endfunction

  function automatic int expWarm();
    return 1 << WB;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeCmd(logic [3:0] c);
    cmdData = c;
    cmdWrEn = 1'b1;
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic chkHold(string req);
    chk({req, " oscEn"}, int'(oscEn), 0);
    chk({req, " cpuFreeze"}, int'(cpuFreeze), 1);
    chk({req, " tgClear"}, int'(tgClear), 1);
  endtask

  // waits for the end of hold, then measures warm-up
  task automatic runWarm(bit skipped);
    int cnt = 0;
    int bad = 0;
    int w = 0;
    while (tgClear && w < 8) begin w++; tick(1); end
    chk("R4 hold left", int'(tgClear), 0);
    while (cpuFreeze && !cpuRun && cnt < 1000) begin
      if (!oscEn || tgClear) bad++;
      cnt++;
      tick(1);
    end
    chk("R8 warm length", cnt, expWarm());
    chk(skipped ? "R5 no osc stop" : "R8 osc on", bad, 0);
    chk("R9 run pulse", int'(cpuRun), 1);
    chk("R9 unfrozen", int'(cpuFreeze), 0);
    tick(1);
    chk("R9 pulse single", int'(cpuRun), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic p, l;
    int   mode, pre;
    logic [3:0] c;
    void'($urandom(32'd4711));
    rstN = 1'b0; cmdWrEn = 1'b0; cmdData = '0; holdPin = 1'b0; portLatch = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 oscEn", int'(oscEn), 1);
    chk("R1 cpuFreeze", int'(cpuFreeze), 0);
    chk("R1 tgClear", int'(tgClear), 0);
    chk("R1 cpuRun", int'(cpuRun), 0);

    // R2 status mirror, R11 masking by the latch
    for (int i = 0; i < 16; i++) begin
      p = 1'($urandom); l = 1'($urandom);
      holdPin = p; portLatch = l;
      tick(2);
      chk(l ? "R2 status" : "R11 masked status", int'(statusHold), expStatus(p, l));
    end

    // R3 level hold, R11 latch mask, R10 writes during hold, R4 release
    holdPin = 1'b0; portLatch = 1'b1; tick(3);
    writeCmd(4'b1101);
    chkHold("R3");
    holdPin = 1'b1; portLatch = 1'b0; tick(6);
    chkHold("R11");
    writeCmd(4'b1010); writeCmd(4'b0000); writeCmd(4'b1101);
    chkHold("R10 in hold");
    portLatch = 1'b1;
    runWarm(1'b0);

    // R5 skip: level command while wake line is high
    tick(2);
    writeCmd(4'b1101);
    chk("R5 oscEn", int'(oscEn), 1);
    chk("R5 tgClear", int'(tgClear), 0);
    chk("R5 frozen", int'(cpuFreeze), 1);
    runWarm(1'b1);

    // R6/R7 edge mode entered with the line high
    writeCmd(4'b1010);
    chkHold("R6 high");
    tick(20);
    chkHold("R7 steady high");
    holdPin = 1'b0; tick(5);
    chkHold("R7 falling");
    holdPin = 1'b1;
    runWarm(1'b0);

    // R6 edge mode entered with the line low
    holdPin = 1'b0; tick(3);
    writeCmd(4'b1010);
    chkHold("R6 low");
    tick(4);
    holdPin = 1'b1;
    runWarm(1'b0);

    // R10 other codes ignored in run
    for (int i = 0; i < 10; i++) begin
      c = 4'($urandom);
      if (c == 4'b1101 || c == 4'b1010) c = 4'b0111;
      holdPin = 1'($urandom);
      writeCmd(c);
      tick(1);
      chk("R10 freeze", int'(cpuFreeze), 0);
      chk("R10 osc", int'(oscEn), 1);
      chk("R10 tg", int'(tgClear), 0);
    end

    // random mix of modes and wake levels
    for (int it = 0; it < 8; it++) begin
      mode = int'($urandom % 2);
      pre  = int'($urandom % 2);
      portLatch = 1'b1;
      holdPin = pre[0];
      tick(3);
      writeCmd(mode == 1 ? 4'b1010 : 4'b1101);
      if (mode == 0 && pre == 1) begin
        chk("R5 rnd osc", int'(oscEn), 1);
        runWarm(1'b1);
      end else begin
        chkHold(mode == 1 ? "R6 rnd" : "R3 rnd");
        tick(3 + int'($urandom % 20));
        chkHold(mode == 1 ? "R7 rnd" : "R3 rnd hold");
        if (mode == 1 && pre == 1) begin
          holdPin = 1'b0; tick(3);
          chkHold("R7 rnd fall");
        end
        holdPin = 1'b1;
        runWarm(1'b0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule